// File: doc/BRIEF.md
# Two-Wire Serial Clock Phase Timer

This block times the serial clock of a two-wire bus master. The clock runs as an endless sequence of low and high phases. A single configuration word sets the length of each phase: a low-phase divider, a high-phase divider and a shared power-of-two prescale exponent. Each phase lasts the divider shifted left by the exponent, plus three extra system clock cycles. Exponent values above 4 are treated as 4.

The master drives the bus clock low while `scl_out` is 0 and releases it while `scl_out` is 1. It feeds the sampled bus clock back on `scl_in`. The high phase counts only the cycles in which the line is actually seen high, so any device that holds the line low stretches the clock. Two single-cycle strobes mark the last cycle of each low phase and of each high phase. The master uses them to set up and sample data.

Top module: `scl_timer`

## Requirements
- R1: A low phase holds `scl_out` at 0 for exactly (L << min(E,4)) + 3 system clock cycles. L is `cfg_word[7:0]` and E is `cfg_word[18:16]`.
- R2: A high phase lasts until (H << min(E,4)) + 3 cycles have been counted in which `scl_out` is 1 and `scl_in` is 1. H is `cfg_word[15:8]`. Cycles in which `scl_in` is low are not counted, and `scl_out` stays 1 through them.
- R3: Exponent values 5, 6 and 7 give the same phase lengths as exponent 4.
- R4: The low divider and the high divider act independently. Each sets only its own phase. A divider of 0 gives a 3-cycle phase, and 255 with exponent 4 gives 4083 cycles.
- R5: The configuration word is sampled once, at the clock edge that starts a phase. A change made during a phase takes effect at the next phase start. When the block leaves idle, it uses the word present at that edge.
- R6: `low_end` is 1 for exactly the last cycle of each low phase. `scl_out` is 1 in the following cycle.
- R7: `high_end` is 1 for exactly the last counted cycle of each high phase. `scl_out` is 0 in the following cycle.
- R8: While `enable` is low, from the first clock edge that samples it low, `scl_out` is 1 and both strobes are 0. The next enable starts a fresh low phase of full length.
- R9: During reset, `scl_out` is 1 and both strobes are 0.
- R10: The clock edge that first samples `enable` high starts a low phase, so `scl_out` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock; when low, release the line and clear the count |
| cfg_word | input | 19 | Timing word: exponent [18:16], high divider [15:8], low divider [7:0] |
| scl_in | input | 1 | Sampled level of the bus clock line |
| scl_out | output | 1 | 0 = pull the line low, 1 = release it |
| low_end | output | 1 | Strobe during the last cycle of a low phase |
| high_end | output | 1 | Strobe during the last cycle of a high phase |

## Verification
The register chain is one stage deep. An edge that samples `enable` or a phase boundary changes `scl_out` in the very next cycle. The strobes are decoded from that same state, so each strobe shares its cycle with the final cycle of its phase. Stimulus changes 1 ns after a rising edge and every output is read at the falling edge. A phase is judged by the configuration word seen at the falling edge before the edge that began it. A phase is checked only if `enable` was seen high at every edge within it.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 4,
  localparam int CFG_W  = 2*DIV_W + EXP_W,
  localparam int CNT_W  = $clog2(((2**DIV_W) - 1) * (2**EXP_MAX) + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_in,
  output logic             scl_out,
  output logic             low_end,
  output logic             high_end
);

  typedef enum logic [1:0] {IDLE, LOW, HIGH} phase_t;

  phase_t           st;
  logic [CNT_W-1:0] cnt;

  wire [DIV_W-1:0] lo_div = cfg_word[DIV_W-1:0];
  wire [DIV_W-1:0] hi_div = cfg_word[2*DIV_W-1:DIV_W];
  wire [EXP_W-1:0] expo   = cfg_word[CFG_W-1:2*DIV_W];
  wire             at_end = (cnt == '0);

  function automatic logic [CNT_W-1:0] last_idx(input logic [DIV_W-1:0] d,
                                                 input logic [EXP_W-1:0] e);
    int sh;
    sh = (int'(e) > EXP_MAX) ? EXP_MAX : int'(e);
    return (CNT_W'(d) << sh) + CNT_W'(2);
  endfunction

  assign scl_out  = (st != LOW);
  assign low_end  = (st == LOW)  && at_end;
  assign high_end = (st == HIGH) && at_end && scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: begin
          st  <= LOW;
          cnt <= last_idx(lo_div, expo);
        end
        LOW: begin
          if (at_end) begin
            st  <= HIGH;
            cnt <= last_idx(hi_div, expo);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        HIGH: begin
          if (scl_in) begin
            if (at_end) begin
              st  <= LOW;
              cnt <= last_idx(lo_div, expo);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: begin
          st  <= IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (scl_out && !low_end && !high_end)); // R8
  AST_LOW_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_out) && enable) |=> !scl_out); // R1
  AST_LOW_END_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (low_end && enable) |=> (scl_out && !low_end)); // R6
  AST_HIGH_END_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (high_end && enable) |=> (!scl_out && !high_end)); // R7
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_out && !scl_in) |-> !high_end); // R2

endmodule

// File: tb/scl_timer_test.sv
`timescale 1ns/1ps
module scl_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        enable = 0;
  logic [18:0] cfg_word = '0;
  logic        stretch = 0;
  logic        scl_out, low_end, high_end;
  wire         scl_line = scl_out & ~stretch;

  int checks = 0, fails = 0, cyc = 0;
  string focus = "R4";

  scl_timer uut (.clk(clk), .rst_n(rst_n), .enable(enable), .cfg_word(cfg_word),
                 .scl_in(scl_line), .scl_out(scl_out), .low_end(low_end), .high_end(high_end));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int dur(input logic [7:0] d, input logic [2:0] e);
    int sh = (e > 3'd4) ? 4 : int'(e); // R3 clamp
    return (int'(d) << sh) + 3;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(0, "watchdog", cyc, 190000);
      report();
    end
  end

  logic        prev_out = 1, prev_le = 0, prev_he = 0, prev_en = 0;
  logic [18:0] cfg_prev = '0;
  bit          lo_ok = 0, hi_ok = 0;
  int          lo_n = 0, hi_n = 0, lo_x = 0, hi_x = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(scl_out && !low_end && !high_end, "R9", {scl_out, low_end, high_end}, 3'b100);
    end else begin
      if (!enable && !prev_en)
        chk(scl_out && !low_end && !high_end, "R8", {scl_out, low_end, high_end}, 3'b100);
      if (prev_le && prev_en) chk(scl_out == 1'b1, "R6", scl_out, 1);
      if (prev_he && prev_en) chk(scl_out == 1'b0, "R7", scl_out, 0);
      if (!prev_en) begin lo_ok = 0; hi_ok = 0; end
      if (!scl_out && prev_out) begin
        if (hi_ok && prev_en) begin
          chk(hi_n == hi_x, {"R2/", focus}, hi_n, hi_x);
          chk(prev_he, "R7", prev_he, 1);
        end
        hi_ok = 0;
        lo_ok = prev_en;
        lo_n  = 0;
        lo_x  = dur(cfg_prev[7:0], cfg_prev[18:16]);
      end
      if (!scl_out) lo_n++;
      if (scl_out && !prev_out) begin
        if (lo_ok && prev_en) begin
          chk(lo_n == lo_x, {"R1/", focus}, lo_n, lo_x);
          chk(prev_le, "R6", prev_le, 1);
        end
        lo_ok = 0;
        hi_ok = prev_en;
        hi_n  = 0;
        hi_x  = dur(cfg_prev[15:8], cfg_prev[18:16]);
      end
      if (scl_out && scl_line) hi_n++;
    end
    prev_out = scl_out; prev_le = low_end; prev_he = high_end;
    prev_en  = enable && rst_n; cfg_prev = cfg_word;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    tick(4);
    rst_n = 1;
    // R10 and R4: independent dividers 2 and 9, exponent 0
    cfg_word = {3'd0, 8'd9, 8'd2};
    enable = 1;
    @(negedge clk); @(negedge clk);
    chk(scl_out == 1'b0, "R10", scl_out, 0);
    tick(80);
    // R3: exponents above 4 behave as 4
    focus = "R3";
    for (int e = 4; e < 8; e++) begin
      cfg_word = {3'(e), 8'd1, 8'd2};
      tick(120);
    end
    // R4: zero and maximum dividers
    focus = "R4";
    cfg_word = {3'd0, 8'd0, 8'd0};
    tick(40);
    cfg_word = {3'd4, 8'd255, 8'd255};
    tick(9000);
    cfg_word = {3'd2, 8'd0, 8'd255};
    tick(3000);
    // R5: change in mid phase only applies at the next phase start
    focus = "R5";
    cfg_word = {3'd0, 8'd200, 8'd200};
    tick(300);
    cfg_word = {3'd0, 8'd3, 8'd3};
    tick(300);
    // R8: disable mid phase, then restart with a full low phase
    enable = 0;
    @(negedge clk); @(negedge clk);
    chk(scl_out && !low_end && !high_end, "R8", scl_out, 1);
    tick(5);
    cfg_word = {3'd1, 8'd4, 8'd7};
    enable = 1;
    tick(100);
    // R2: stretch the start of a high phase
    focus = "R2";
    cfg_word = {3'd0, 8'd5, 8'd5};
    tick(20);
    while (!(scl_out && !low_end)) tick(1);
    stretch = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(scl_out && !high_end, "R2", scl_out, 1);
      tick(1);
    end
    stretch = 0;
    tick(60);
    // random mix
    focus = "R5";
    for (int i = 0; i < 150; i++) begin
      int n = 20 + int'($urandom % 300);
      cfg_word = {3'($urandom % 8), 8'($urandom % 40), 8'($urandom % 40)};
      for (int k = 0; k < n; k++) begin
        tick(1);
        stretch = ($urandom % 6) == 0;
        enable  = ($urandom % 400) != 0;
      end
    end
    stretch = 0;
    tick(20);
    report();
  end
endmodule